// File: doc/BRIEF.md
# Configuration Base Address Register Bank with Memory Decoder

This block holds the six base address slots of one PCI endpoint's configuration header and decodes memory request addresses against them. Software programs each implemented slot through a dword-wide configuration port. It finds the size of a slot by writing all ones and reading the slot back.

The slot at offset 0x10 is the lower dword of a 64-bit prefetchable window. Offset 0x14 carries that window's upper 32 address bits. Offsets 0x18 and 0x24 are 32-bit non-prefetchable windows. Offsets 0x1C and 0x20 are not implemented. Window sizes are powers of two given as log2 parameters, each at least 4 (16 bytes).

On the memory side, a request address is compared with every programmed window. The decoder reports a hit with a region code and a region-relative offset, or a miss when no window claims the address.

Top module: `pci_bar_bank`

## Requirements
- R1: After reset every implemented base is zero. A read of offset 0x10 returns 0x0000000C, and reads of 0x14, 0x18 and 0x24 return 0.
- R2: The low four bits read from offset 0x10 are always 0xC. The low four bits read from offsets 0x18 and 0x24 are always 0.
- R3: A base write stores only the written bits at and above log2 of that window's size. All lower bits read back as zero, apart from the fixed type bits of R2.
- R4: Writing 0xFFFFFFFF to offset 0x10, 0x18 or 0x24 leaves the stored base unchanged. The next read of that offset returns ~(size-1) with its low four bits replaced by the type bits. Every later read returns the base again.
- R5: A write to offset 0x14 sets address bits 63:32 of the 64-bit window, keeping only the bits at and above log2 size minus 32. After an all-ones write to 0x14, the next read of 0x14 returns bits 63:32 of ~(size-1).
- R6: Offsets 0x1C and 0x20, and every offset outside 0x10 to 0x27, read as 0. Writes to them change nothing.
- R7: A configuration write whose byte enables are not all four set (cfg_be other than 4'hF) changes no base and starts no probe.
- R8: A valid request address A with base <= A < base+size for an implemented window raises mem_hit. mem_offset is then A minus that base. A 32-bit window can only match when A[63:32] is zero.
- R9: A valid request that matches no window raises mem_miss. mem_hit and mem_miss are never both high, and both stay low while mem_valid is low.
- R10: mem_region is 0 for the 64-bit window, 2 for the window at 0x18 and 5 for the window at 0x24. When windows overlap, the priority is 0, then 2, then 5.
- R11: cfg_rdata takes the value of the offset presented with cfg_re one clock edge later. It holds that value in every cycle in which cfg_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 12 | Configuration byte offset (dword aligned) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| mem_valid | input | 1 | Memory request present |
| mem_addr | input | 64 | Memory request address |
| mem_hit | output | 1 | Request falls in a window |
| mem_miss | output | 1 | Request falls in no window |
| mem_region | output | 3 | Slot number of the matching window |
| mem_offset | output | 64 | Address relative to the matching base |

## Verification
The bench tests the edges of every window: one below the base, the base itself, the middle, the last byte and one past the end. A wrong compare width or an off-by-one bound would turn one of these points into a false hit or a false miss.

The bench also reads every slot once after a probe and again after that. A probe that sticks, never clears, or overwrites the base fails one of those two reads.

Partial-byte-enable writes and writes to the unused slots are checked by reading the slots back. Two windows are placed so that they overlap, and a request in the shared range must report the higher-priority slot. An upper-half address is checked against a 32-bit window, which must reject it.

// File: rtl/pci_bar_bank.sv
module pci_bar_bank #(
  parameter int SZ0_LOG2 = 20,
  parameter int SZ2_LOG2 = 12,
  parameter int SZ5_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [11:0] cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_valid,
  input  logic [63:0] mem_addr,
  output logic        mem_hit,
  output logic        mem_miss,
  output logic [2:0]  mem_region,
  output logic [63:0] mem_offset
);
  localparam logic [63:0] MASK0 = ~((64'd1 << SZ0_LOG2) - 64'd1);
  localparam logic [63:0] MASK2W = ~((64'd1 << SZ2_LOG2) - 64'd1);
  localparam logic [63:0] MASK5W = ~((64'd1 << SZ5_LOG2) - 64'd1);
  localparam logic [31:0] MASK2 = MASK2W[31:0];
  localparam logic [31:0] MASK5 = MASK5W[31:0];

  logic [63:0] base0;
  logic [31:0] base2, base5;
  logic [3:0]  probe;
  logic [31:0] rd_mux;

  wire full = cfg_we && (cfg_be == 4'hF);
  wire ones = (cfg_wdata == 32'hFFFF_FFFF);
  wire s10 = (cfg_addr == 12'h010);
  wire s14 = (cfg_addr == 12'h014);
  wire s18 = (cfg_addr == 12'h018);
  wire s24 = (cfg_addr == 12'h024);

  always_comb begin
    rd_mux = 32'h0;
    if (s10) rd_mux = probe[0] ? {MASK0[31:4], 4'hC} : {base0[31:4], 4'hC};
    if (s14) rd_mux = probe[1] ? MASK0[63:32] : base0[63:32];
    if (s18) rd_mux = probe[2] ? {MASK2[31:4], 4'h0} : base2;
    if (s24) rd_mux = probe[3] ? {MASK5[31:4], 4'h0} : base5;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base0     <= '0;
      base2     <= '0;
      base5     <= '0;
      probe     <= '0;
      cfg_rdata <= '0;
    end else begin
      if (full && s10) begin
        if (ones) probe[0] <= 1'b1;
        else begin base0[31:0] <= cfg_wdata & MASK0[31:0]; probe[0] <= 1'b0; end
      end
      if (full && s14) begin
        if (ones) probe[1] <= 1'b1;
        else begin base0[63:32] <= cfg_wdata & MASK0[63:32]; probe[1] <= 1'b0; end
      end
      if (full && s18) begin
        if (ones) probe[2] <= 1'b1;
        else begin base2 <= cfg_wdata & MASK2; probe[2] <= 1'b0; end
      end
      if (full && s24) begin
        if (ones) probe[3] <= 1'b1;
        else begin base5 <= cfg_wdata & MASK5; probe[3] <= 1'b0; end
      end
      if (cfg_re) begin
        cfg_rdata <= rd_mux;
        if (s10) probe[0] <= 1'b0;
        if (s14) probe[1] <= 1'b0;
        if (s18) probe[2] <= 1'b0;
        if (s24) probe[3] <= 1'b0;
      end
    end
  end

  wire up_zero = (mem_addr[63:32] == 32'h0);
  wire h0 = ((mem_addr & MASK0) == base0);
  wire h2 = up_zero && ((mem_addr[31:0] & MASK2) == base2);
  wire h5 = up_zero && ((mem_addr[31:0] & MASK5) == base5);

  always_comb begin
    mem_region = 3'd0;
    mem_offset = 64'h0;
    if (h0) begin
      mem_region = 3'd0;
      mem_offset = mem_addr - base0;
    end else if (h2) begin
      mem_region = 3'd2;
      mem_offset = mem_addr - {32'h0, base2};
    end else if (h5) begin
      mem_region = 3'd5;
      mem_offset = mem_addr - {32'h0, base5};
    end
  end

  assign mem_hit  = mem_valid && (h0 || h2 || h5);
  assign mem_miss = mem_valid && !(h0 || h2 || h5);
endmodule

// File: rtl/pci_bar_bank_chk.sv
module pci_bar_bank_chk #(
  parameter int SZ2_LOG2 = 12,
  parameter int SZ5_LOG2 = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_re,
  input logic [11:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        mem_valid,
  input logic        mem_hit,
  input logic        mem_miss,
  input logic [2:0]  mem_region,
  input logic [63:0] mem_offset,
  input logic [63:0] base0,
  input logic [31:0] base2,
  input logic [31:0] base5
);
  a_r2_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && cfg_addr == 12'h010) |=> cfg_rdata[3:0] == 4'hC);

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && (cfg_addr == 12'h01C || cfg_addr == 12'h020)) |=> cfg_rdata == 32'h0);

  a_r7_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be != 4'hF) |=> ($stable(base0) && $stable(base2) && $stable(base5)));

  a_r9_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_hit && mem_miss));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (!mem_hit && !mem_miss));

  a_r8_offset_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit && mem_region == 3'd2) |-> mem_offset < (64'd1 << SZ2_LOG2));

  a_r8_offset_in_window5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit && mem_region == 3'd5) |-> mem_offset < (64'd1 << SZ5_LOG2));

  a_r10_region_code: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (mem_region == 3'd0 || mem_region == 3'd2 || mem_region == 3'd5));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_re |=> $stable(cfg_rdata));
endmodule

bind pci_bar_bank pci_bar_bank_chk #(.SZ2_LOG2(SZ2_LOG2), .SZ5_LOG2(SZ5_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid), .mem_hit(mem_hit),
  .mem_miss(mem_miss), .mem_region(mem_region), .mem_offset(mem_offset),
  .base0(base0), .base2(base2), .base5(base5)
);

// File: tb/pci_bar_bank_tb_top.sv
module pci_bar_bank_tb_top;
  localparam int L0 = 20, L2 = 12, L5 = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_valid = 1'b0;
  logic [63:0] mem_addr = '0;
  logic        mem_hit, mem_miss;
  logic [2:0]  mem_region;
  logic [63:0] mem_offset;

  pci_bar_bank #(.SZ0_LOG2(L0), .SZ2_LOG2(L2), .SZ5_LOG2(L5)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] eb0 = '0, eb2 = '0, eb5 = '0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] keep(input logic [31:0] v, input int lg);
    return (v >> lg) << lg;
  endfunction

  task automatic dec(input string tag, input logic [63:0] a);
    logic ehit;
    logic [2:0] ereg;
    logic [63:0] eoff;
    @(negedge clk);
    mem_valid = 1'b1; mem_addr = a;
    #1;
    ehit = 1'b1; ereg = 3'd0; eoff = 64'h0;
    if (a >= eb0 && a < eb0 + (64'd1 << L0)) begin ereg = 3'd0; eoff = a - eb0; end
    else if (a >= eb2 && a < eb2 + (64'd1 << L2)) begin ereg = 3'd2; eoff = a - eb2; end
    else if (a >= eb5 && a < eb5 + (64'd1 << L5)) begin ereg = 3'd5; eoff = a - eb5; end
    else ehit = 1'b0;
    chk({tag, " R9 hit"}, {63'h0, mem_hit}, {63'h0, ehit});
    chk({tag, " R9 miss"}, {63'h0, mem_miss}, {63'h0, !ehit});
    if (ehit) begin
      chk({tag, " R10 region"}, {61'h0, mem_region}, {61'h0, ereg});
      chk({tag, " R8 offset"}, mem_offset, eoff);
    end
  endtask

  task automatic sweep(input string tag);
    logic [63:0] bs [3];
    int lg [3];
    bs[0] = eb0; bs[1] = eb2; bs[2] = eb5;
    lg[0] = L0; lg[1] = L2; lg[2] = L5;
    for (int i = 0; i < 3; i++) begin
      dec(tag, bs[i] - 64'd1);
      dec(tag, bs[i]);
      dec(tag, bs[i] + (64'd1 << (lg[i] - 1)));
      dec(tag, bs[i] + (64'd1 << lg[i]) - 64'd1);
      dec(tag, bs[i] + (64'd1 << lg[i]));
    end
  endtask

  logic [31:0] d;

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(12'h010, d); chk("R1 reset 0x10", {32'h0, d}, 64'h0000000C);
    rd(12'h014, d); chk("R1 reset 0x14", {32'h0, d}, 64'h0);
    rd(12'h018, d); chk("R1 reset 0x18", {32'h0, d}, 64'h0);
    rd(12'h024, d); chk("R1 reset 0x24", {32'h0, d}, 64'h0);

    // R4 / R5 sizing probes, then base returns
    wr(12'h010, 32'hFFFF_FFFF, 4'hF);
    rd(12'h010, d); chk("R4 probe 0x10", {32'h0, d}, {32'h0, ~((32'd1 << L0) - 32'd1) & 32'hFFFF_FFF0 | 32'hC});
    rd(12'h010, d); chk("R4 after probe 0x10", {32'h0, d}, 64'h0000000C);
    wr(12'h014, 32'hFFFF_FFFF, 4'hF);
    rd(12'h014, d); chk("R5 probe 0x14", {32'h0, d}, 64'hFFFF_FFFF);
    rd(12'h014, d); chk("R5 after probe 0x14", {32'h0, d}, 64'h0);
    wr(12'h018, 32'hFFFF_FFFF, 4'hF);
    rd(12'h018, d); chk("R4 probe 0x18", {32'h0, d}, {32'h0, ~((32'd1 << L2) - 32'd1)});
    rd(12'h018, d); chk("R4 after probe 0x18", {32'h0, d}, 64'h0);
    wr(12'h024, 32'hFFFF_FFFF, 4'hF);
    rd(12'h024, d); chk("R4 probe 0x24", {32'h0, d}, {32'h0, ~((32'd1 << L5) - 32'd1)});
    rd(12'h024, d); chk("R4 after probe 0x24", {32'h0, d}, 64'h0);

    // R6 unused and out-of-range offsets
    wr(12'h01C, 32'hFFFF_FFFF, 4'hF);
    rd(12'h01C, d); chk("R6 probe unused 0x1C", {32'h0, d}, 64'h0);
    wr(12'h020, 32'h1234_5678, 4'hF);
    rd(12'h020, d); chk("R6 unused 0x20", {32'h0, d}, 64'h0);
    wr(12'h028, 32'h1234_5678, 4'hF);
    rd(12'h028, d); chk("R6 outside 0x28", {32'h0, d}, 64'h0);

    // R3 base masking, R2 type bits
    wr(12'h010, 32'h1234_5678, 4'hF);
    wr(12'h014, 32'h0000_0001, 4'hF);
    wr(12'h018, 32'hABCD_EFFF, 4'hF);
    wr(12'h024, 32'h4000_0123, 4'hF);
    eb0 = {32'h1, keep(32'h1234_5678, L0)};
    eb2 = {32'h0, keep(32'hABCD_EFFF, L2)};
    eb5 = {32'h0, keep(32'h4000_0123, L5)};
    rd(12'h010, d); chk("R3 R2 base 0x10", {32'h0, d}, {32'h0, eb0[31:0] | 32'hC});
    rd(12'h014, d); chk("R5 upper 0x14", {32'h0, d}, {32'h0, eb0[63:32]});
    rd(12'h018, d); chk("R3 base 0x18", {32'h0, d}, eb2);
    rd(12'h024, d); chk("R3 base 0x24", {32'h0, d}, eb5);

    // R11 hold while idle
    repeat (4) @(negedge clk);
    chk("R11 hold", {32'h0, cfg_rdata}, eb5);

    // R7 partial writes ignored, no probe started
    for (int be = 0; be < 15; be++) begin
      wr(12'h018, 32'hFFFF_FFFF, 4'(be));
      wr(12'h024, 32'h0000_0000, 4'(be));
    end
    rd(12'h018, d); chk("R7 partial 0x18", {32'h0, d}, eb2);
    rd(12'h024, d); chk("R7 partial 0x24", {32'h0, d}, eb5);

    // R8 R9 R10 decode sweep
    sweep("R8 sweep");
    dec("R8 upper half vs 32-bit", 64'h1_0000_0000 | eb2);
    dec("R9 far miss", 64'h0000_0000_0000_1000);
    @(negedge clk); mem_valid = 1'b0; mem_addr = eb2; #1;
    chk("R9 idle no hit", {63'h0, mem_hit}, 64'h0);
    chk("R9 idle no miss", {63'h0, mem_miss}, 64'h0);

    // R10 overlap priority: window 5 inside window 2
    wr(12'h024, 32'hABCD_E100, 4'hF);
    eb5 = {32'h0, keep(32'hABCD_E100, L5)};
    sweep("R10 overlap");
    // overlap 0 over 2
    wr(12'h014, 32'h0, 4'hF);
    wr(12'h010, 32'hABC0_0000, 4'hF);
    eb0 = {32'h0, keep(32'hABC0_0000, L0)};
    sweep("R10 overlap0");

    @(negedge clk); mem_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule